// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

The block watches one idle-high serial line and rebuilds characters from it. It uses a programmable bit rate, a character size of five to nine bits, an optional even or odd parity bit and a stop bit. The sampling clock runs at sixteen times the bit rate. A falling edge on the line starts a frame. The start bit is confirmed at its centre, and every later bit is sampled once at its centre.

Each finished character goes into a single-entry receive buffer. A frame-error flag and a parity-error flag travel with that character. A receive-complete flag shows that the buffer holds an unread character, and a read strobe clears it. If a further character completes while the buffer is still unread, that new character is dropped, the older one stays, and an overrun flag is raised. The receiver runs alongside a separate transmitter and shares its line settings, but it works only while its enable input is high.

Top module: `serial_rx`

## Requirements
- R1: One bit period is 16*(baud_div_i+1) clock cycles. A falling edge on the synchronised rx_i line while the receiver is idle starts a frame. The line is sampled again half a bit period later; if it is high there, the event is discarded as a glitch and no character is produced.
- R2: Data bits arrive least significant bit first. The number of data bits comes from char_sz_i: codes 0 to 4 give 5 to 9 bits, and any code above 4 gives 9 bits. The character is right-aligned in data_o, and unused upper bits read as 0.
- R3: parity_mode_i selects parity: 00 and 01 mean no parity bit, 10 means even and 11 means odd. When a parity bit is present and the total count of ones does not match the mode, parity_err_o is 1 for that character. With parity off, parity_err_o is 0.
- R4: frame_err_o is 1 when the first stop bit is sampled low. A second stop bit is never checked; to the receiver it is just idle line.
- R5: When a character completes into an empty buffer, rx_done_o rises and data_o holds the character. A one-cycle rd_i pulse while rx_done_o is 1 clears rx_done_o.
- R6: If a character completes while rx_done_o is 1 and rd_i is low, that character is dropped. data_o and both error flags keep the older character, and overrun_o becomes 1. overrun_o clears when the buffer is read with rd_i.
- R7: While rx_en_i is 0, no character is received and the buffer does not change. Dropping rx_en_i in the middle of a frame abandons that frame.
- R8: frame_err_o and parity_err_o change only when a character is loaded into the buffer. Reading the buffer leaves them as they were.
- R9: After reset, data_o, rx_done_o, frame_err_o, parity_err_o and overrun_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| rx_en_i | input | 1 | Receiver enable |
| baud_div_i | input | 12 | Oversample divider; one tick every baud_div_i+1 cycles |
| char_sz_i | input | 3 | Character size code |
| parity_mode_i | input | 2 | Parity mode |
| rd_i | input | 1 | Buffer read strobe |
| data_o | output | 9 | Buffered character |
| rx_done_o | output | 1 | Buffer holds an unread character |
| frame_err_o | output | 1 | Stop-bit error of the buffered character |
| parity_err_o | output | 1 | Parity error of the buffered character |
| overrun_o | output | 1 | A character was dropped because the buffer was full |

## Verification
Characters are sent at the 5-, 8- and 9-bit sizes, including a size code above 4. Bit patterns are chosen so that a wrong bit order or a wrong bit count gives a visibly different value. Even and odd parity are each tried with a correct and with a flipped parity bit, which separates the two senses from each other and from the parity-off mode. A low stop bit, a short low glitch, a frame sent while disabled and a frame abandoned halfway each test one discard path. Back-to-back characters sent without a read show whether the older character and its flags survive an overrun.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;

  localparam int unsigned MAX_BITS = 9;
  localparam int unsigned MIN_BITS = 5;
  localparam int unsigned OSR      = 16;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic line_o,
  output logic fall_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[1:0], rx_i};
  end

  assign line_o = sh_q[1];
  assign fall_o = sh_q[2] & ~sh_q[1];
endmodule

// File: rtl/serial_rx_tick.sv
module serial_rx_tick #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == div_i);
  assign tick_o = wrap & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i||wrap) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int unsigned OS_RATE = OSR,
  parameter int unsigned DATA_W  = MAX_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              line_i,
  input  logic              fall_i,
  input  logic              tick_i,
  input  logic [2:0]        char_sz_i,
  input  logic [1:0]        parity_mode_i,
  output logic              idle_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              frame_err_o,
  output logic              parity_err_o
);
  localparam int unsigned OS_W  = $clog2(OS_RATE);
  localparam int unsigned IDX_W = $clog2(DATA_W);
  localparam logic [OS_W-1:0] OS_LAST = OS_W'(OS_RATE - 1);
  localparam logic [OS_W-1:0] OS_MID  = OS_W'(OS_RATE / 2 - 1);

  rx_state_t         st_q;
  logic [OS_W-1:0]   os_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  last_idx;
  logic [DATA_W-1:0] sh_q;
  logic              acc_q, fe_q, pe_q, done_q;
  logic              par_en, at_mid, at_end;

  assign last_idx = (char_sz_i > 3'd4) ? IDX_W'(DATA_W - 1)
                                       : IDX_W'(char_sz_i) + IDX_W'(MIN_BITS - 1);
  assign par_en   = parity_mode_i[1];
  assign at_mid   = tick_i && (os_q == OS_MID);
  assign at_end   = tick_i && (os_q == OS_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      os_q   <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      acc_q  <= 1'b0;
      fe_q   <= 1'b0;
      pe_q   <= 1'b0;
      done_q <= 1'b0;
    end else if (!en_i) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i && st_q != ST_IDLE) os_q <= os_q + 1'b1;
      unique case (st_q)
        ST_IDLE: if (fall_i) begin
          st_q <= ST_START;
          os_q <= '0;
        end
        ST_START: if (at_mid) begin
          os_q <= '0;
          if (line_i) st_q <= ST_IDLE;   // glitch
          else begin
            st_q  <= ST_DATA;
            idx_q <= '0;
            sh_q  <= '0;
            acc_q <= 1'b0;
            pe_q  <= 1'b0;
          end
        end
        ST_DATA: if (at_end) begin
          sh_q[idx_q] <= line_i;
          acc_q       <= acc_q ^ line_i;
          if (idx_q == last_idx) st_q <= par_en ? ST_PAR : ST_STOP;
          else                   idx_q <= idx_q + 1'b1;
        end
        ST_PAR: if (at_end) begin
          pe_q <= acc_q ^ line_i ^ parity_mode_i[0];
          st_q <= ST_STOP;
        end
        ST_STOP: if (at_end) begin
          fe_q   <= ~line_i;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o       = (st_q == ST_IDLE);
  assign done_o       = done_q;
  assign data_o       = sh_q;
  assign frame_err_o  = fe_q;
  assign parity_err_o = pe_q;
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import serial_rx_pkg::*;
#(
  parameter int unsigned DIV_W  = 12,
  parameter int unsigned DATA_W = MAX_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              rx_en_i,
  input  logic [DIV_W-1:0]  baud_div_i,
  input  logic [2:0]        char_sz_i,
  input  logic [1:0]        parity_mode_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rx_done_o,
  output logic              frame_err_o,
  output logic              parity_err_o,
  output logic              overrun_o
);
  logic              line, fall, tick, frm_idle, frm_done;
  logic              frm_fe, frm_pe;
  logic [DATA_W-1:0] frm_data;

  serial_rx_sync u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rx_i  (rx_i),
    .line_o(line),
    .fall_o(fall)
  );

  serial_rx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (frm_idle),
    .div_i (baud_div_i),
    .tick_o(tick)
  );

  serial_rx_frame #(.OS_RATE(OSR), .DATA_W(DATA_W)) u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (rx_en_i),
    .line_i       (line),
    .fall_i       (fall),
    .tick_i       (tick),
    .char_sz_i    (char_sz_i),
    .parity_mode_i(parity_mode_i),
    .idle_o       (frm_idle),
    .done_o       (frm_done),
    .data_o       (frm_data),
    .frame_err_o  (frm_fe),
    .parity_err_o (frm_pe)
  );

  logic [DATA_W-1:0] buf_q;
  logic              full_q, fe_q, pe_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      fe_q   <= 1'b0;
      pe_q   <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (rd_i && full_q) begin
        full_q <= 1'b0;
        ovr_q  <= 1'b0;
      end
      if (frm_done) begin
        if (full_q && !rd_i) ovr_q <= 1'b1;  // keep older char
        else begin
          buf_q  <= frm_data;
          fe_q   <= frm_fe;
          pe_q   <= frm_pe;
          full_q <= 1'b1;
        end
      end
    end
  end

  assign data_o       = buf_q;
  assign rx_done_o    = full_q;
  assign frame_err_o  = fe_q;
  assign parity_err_o = pe_q;
  assign overrun_o    = ovr_q;
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
  parameter int unsigned DATA_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_en_i,
  input logic              rd_i,
  input logic              frm_done,
  input logic [DATA_W-1:0] data_o,
  input logic              rx_done_o,
  input logic              frame_err_o,
  input logic              parity_err_o,
  input logic              overrun_o
);
  p_done_fills_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_done |=> rx_done_o);

  p_read_empties_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && rx_done_o && !frm_done |=> !rx_done_o);

  p_overrun_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_done && rx_done_o && !rd_i |=> overrun_o && $stable(data_o) && $stable(frame_err_o));

  p_overrun_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(frm_done));

  p_flags_follow_char_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_done |=> $stable(frame_err_o) && $stable(parity_err_o));

  p_disabled_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i && $past(!rx_en_i) && !rd_i |=> $stable(data_o) && $stable(rx_done_o));
endmodule

bind serial_rx serial_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_en_i     (rx_en_i),
  .rd_i        (rd_i),
  .frm_done    (frm_done),
  .data_o      (data_o),
  .rx_done_o   (rx_done_o),
  .frame_err_o (frame_err_o),
  .parity_err_o(parity_err_o),
  .overrun_o   (overrun_o)
);

// File: tb/serial_rx_bench.sv
module serial_rx_bench;
  localparam int DIV = 1;
  localparam int BIT = 16 * (DIV + 1);

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_i = 1'b1;
  logic       rx_en_i = 1'b1;
  logic [11:0] baud_div_i = 12'(DIV);
  logic [2:0] char_sz_i = 3'd3;
  logic [1:0] parity_mode_i = 2'b00;
  logic       rd_i = 1'b0;
  logic [8:0] data_o;
  logic       rx_done_o, frame_err_o, parity_err_o, overrun_o;

  int n_chk = 0;
  int n_fail = 0;
  bit summed = 0;

  always #2 clk_i = ~clk_i;

  serial_rx u_serial_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(rx_i), .rx_en_i(rx_en_i),
    .baud_div_i(baud_div_i), .char_sz_i(char_sz_i), .parity_mode_i(parity_mode_i),
    .rd_i(rd_i), .data_o(data_o), .rx_done_o(rx_done_o),
    .frame_err_o(frame_err_o), .parity_err_o(parity_err_o), .overrun_o(overrun_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!summed) begin
      summed = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  task automatic send(input logic [8:0] d, input logic [2:0] code,
                      input logic [1:0] pm, input bit bad_par, input bit stop_v);
    int nb;
    logic [8:0] m;
    nb = (code > 3'd4) ? 9 : int'(code) + 5;
    m = d & 9'((1 << nb) - 1);
    @(negedge clk_i);
    char_sz_i = code;
    parity_mode_i = pm;
    rx_i = 1'b0;
    repeat (BIT) @(negedge clk_i);
    for (int i = 0; i < nb; i++) begin
      rx_i = m[i];
      repeat (BIT) @(negedge clk_i);
    end
    if (pm[1]) begin
      rx_i = (^m) ^ pm[0] ^ bad_par;
      repeat (BIT) @(negedge clk_i);
    end
    rx_i = stop_v;
    repeat (BIT) @(negedge clk_i);
    rx_i = 1'b1;
    repeat (BIT) @(negedge clk_i);
  endtask

  task automatic rd_pulse();
    @(negedge clk_i);
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(data_o == 0 && !rx_done_o && !frame_err_o && !parity_err_o && !overrun_o,
        "R9 reset state", {data_o, rx_done_o, frame_err_o, parity_err_o, overrun_o}, 0);
  endtask

  task automatic t_basic();
    send(9'h0A5, 3'd3, 2'b00, 0, 1);
    chk(rx_done_o == 1, "R5 done after char", rx_done_o, 1);
    chk(data_o == 9'h0A5, "R2 8-bit lsb first", data_o, 9'h0A5);
    chk(!frame_err_o && !parity_err_o, "R3 R4 clean flags", {frame_err_o, parity_err_o}, 0);
    rd_pulse();
    chk(rx_done_o == 0, "R5 read clears done", rx_done_o, 0);
  endtask

  task automatic t_sizes();
    send(9'h1F3, 3'd0, 2'b00, 0, 1);
    chk(data_o == 9'h013, "R2 5-bit char", data_o, 9'h013);
    rd_pulse();
    send(9'h1A5, 3'd4, 2'b00, 0, 1);
    chk(data_o == 9'h1A5, "R2 9-bit char", data_o, 9'h1A5);
    rd_pulse();
    send(9'h15A, 3'd7, 2'b00, 0, 1);
    chk(data_o == 9'h15A, "R2 code above 4 is 9 bits", data_o, 9'h15A);
    rd_pulse();
  endtask

  task automatic t_parity();
    send(9'h0B1, 3'd3, 2'b10, 0, 1);
    chk(!parity_err_o && data_o == 9'h0B1, "R3 even ok", parity_err_o, 0);
    rd_pulse();
    send(9'h0B1, 3'd3, 2'b10, 1, 1);
    chk(parity_err_o == 1, "R3 even bad", parity_err_o, 1);
    rd_pulse();
    send(9'h037, 3'd3, 2'b11, 0, 1);
    chk(!parity_err_o && data_o == 9'h037, "R3 odd ok", parity_err_o, 0);
    rd_pulse();
    send(9'h037, 3'd3, 2'b11, 1, 1);
    chk(parity_err_o == 1 && data_o == 9'h037, "R3 odd bad", parity_err_o, 1);
    rd_pulse();
    send(9'h037, 3'd3, 2'b01, 0, 1);
    chk(!parity_err_o && data_o == 9'h037, "R3 mode 01 no parity", parity_err_o, 0);
    rd_pulse();
  endtask

  task automatic t_frame_err();
    send(9'h05C, 3'd3, 2'b00, 0, 0);
    chk(frame_err_o == 1 && data_o == 9'h05C, "R4 low stop bit", frame_err_o, 1);
    rd_pulse();
    chk(frame_err_o == 1, "R8 read keeps flag", frame_err_o, 1);
    send(9'h05D, 3'd3, 2'b00, 0, 1);
    chk(frame_err_o == 0, "R8 flag updates with new char", frame_err_o, 0);
    rd_pulse();
  endtask

  task automatic t_overrun();
    send(9'h011, 3'd3, 2'b00, 0, 1);
    send(9'h022, 3'd3, 2'b00, 0, 0);
    chk(overrun_o == 1, "R6 overrun set", overrun_o, 1);
    chk(data_o == 9'h011, "R6 older char kept", data_o, 9'h011);
    chk(frame_err_o == 0, "R6 R8 dropped char flags unused", frame_err_o, 0);
    rd_pulse();
    chk(overrun_o == 0 && rx_done_o == 0, "R6 read clears overrun", {overrun_o, rx_done_o}, 0);
  endtask

  task automatic t_glitch();
    @(negedge clk_i);
    rx_i = 1'b0;
    repeat (6) @(negedge clk_i);
    rx_i = 1'b1;
    repeat (14 * BIT) @(negedge clk_i);
    chk(rx_done_o == 0, "R1 glitch discarded", rx_done_o, 0);
    send(9'h0C3, 3'd3, 2'b00, 0, 1);
    chk(rx_done_o == 1 && data_o == 9'h0C3, "R1 start after glitch", data_o, 9'h0C3);
    rd_pulse();
  endtask

  task automatic t_disable();
    @(negedge clk_i);
    rx_en_i = 1'b0;
    send(9'h066, 3'd3, 2'b00, 0, 1);
    chk(rx_done_o == 0 && data_o == 9'h0C3, "R7 disabled ignores frame", data_o, 9'h0C3);
    rx_en_i = 1'b1;
    @(negedge clk_i);
    rx_i = 1'b0;
    repeat (3 * BIT) @(negedge clk_i);
    rx_en_i = 1'b0;
    rx_i = 1'b1;
    repeat (2 * BIT) @(negedge clk_i);
    rx_en_i = 1'b1;
    repeat (14 * BIT) @(negedge clk_i);
    chk(rx_done_o == 0, "R7 aborted frame gives nothing", rx_done_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    t_basic();
    t_sizes();
    t_parity();
    t_frame_err();
    t_overrun();
    t_glitch();
    t_disable();
    summary();
    $finish;
  end
endmodule